// File: doc/BRIEF.md
# HDLC Transmit Framer for AX.25 Bursts

This block turns queued AX.25 frame bytes into the serial bit stream that feeds an audio modulator. Software or an upstream engine writes frame bytes into an internal byte queue and marks the final byte of each frame. Once a whole frame is waiting, the framer keys the transmitter and pulls the burst out one bit per handshake. Every burst has the same shape. It opens with a programmable run of preamble flags and then header flags. Each frame follows as bit-stuffed data and a bit-stuffed 16-bit frame check sequence. A closing run of tail flags ends the burst.

When another complete frame is already queued as a frame's check sequence finishes, that frame follows in the same burst. A single flag between the two serves as the closing delimiter of one frame and the opening delimiter of the next. The modulator sets the pace. It raises `tx_ready` whenever it wants a bit, and the framer holds the offered bit until it is taken.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `ptt` and `tx_valid` are low and `wr_ready` is high.
- R2: No burst starts while the queue holds no byte written with `wr_last` high. A partially written frame leaves `ptt` and `tx_valid` low.
- R3: A burst opens with `cfg_preamble` flags followed by max(`cfg_header`,1) flags. A flag is the byte 0x7E, sent least significant bit first as 0,1,1,1,1,1,1,0, and flags are never bit-stuffed.
- R4: Frame bytes are sent least significant bit first. In data and check-sequence bits, a 0 is inserted after every run of five consecutive 1s, and the run carries across byte boundaries and from data into the check sequence.
- R5: The check sequence is the CRC-16 with reflected polynomial 0x8408, initial value 0xFFFF, complemented at the end. It covers the frame's data bits and is sent low byte first, each byte least significant bit first.
- R6: If another complete frame is queued when a frame's check sequence ends, exactly one flag follows, then that frame's data, within the same burst.
- R7: When no further complete frame is queued, the check sequence is followed by max(`cfg_tail`,1) flags, and `ptt` falls in the cycle after the last tail bit is taken.
- R8: A bit offered with `tx_valid` high stays unchanged until `tx_ready` takes it, and the stream advances only on `tx_valid && tx_ready`.
- R9: `ptt` equals `tx_valid` at all times. It rises with the first offered bit of a burst and stays high to the end of the burst.
- R10: `wr_ready` is low exactly when the queue holds FIFO_DEPTH bytes. The three flag counts are captured when a burst starts, and changing them during a burst has no effect on it.
- R11: A preamble count of 0 produces no preamble flags, so the burst opens directly with the header flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_preamble | input | CNT_W | Number of preamble flags (0 allowed) |
| cfg_header | input | CNT_W | Number of header flags (0 treated as 1) |
| cfg_tail | input | CNT_W | Number of tail flags (0 treated as 1) |
| wr_valid | input | 1 | Byte write request |
| wr_data | input | 8 | Frame byte to queue |
| wr_last | input | 1 | Marks the final byte of a frame |
| wr_ready | output | 1 | Queue has room; a write is accepted when valid and ready |
| tx_ready | input | 1 | Modulator takes the offered bit |
| tx_valid | output | 1 | A bit is offered |
| tx_bit | output | 1 | Offered bit value |
| ptt | output | 1 | Transmitter key, high for the whole burst |

## Verification
The bench builds the framer with its default FIFO_DEPTH of 16 and 8-bit flag counts. With that depth, a single 16-byte frame fills the queue, so the full condition can be observed before the first byte drains. The 8-bit counts let the zero cases for preamble, header and tail sit in the same runs as nonzero ones. The bench sweeps all 256 single-byte frames and a few multi-byte and multi-frame bursts, including stuffing runs that cross byte boundaries. It takes bits under an irregular ready pattern. The captured stream is compared bit by bit against a stream that the bench stuffs and checksums independently.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_DATA,
    ST_FCS,
    ST_SEP,
    ST_TAIL
  } tx_state_t;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_SEED     = 16'hFFFF;
  localparam logic [2:0]  RUN_LIMIT    = 3'd5;

  // One LSB-first step of the reflected CRC-16.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = {1'b0, c[15:1]} ^ (fb ? CRC_POLY_REV : 16'h0000);
  endfunction

  // Flag counts of zero are raised to one where a delimiter is mandatory.
  function automatic logic [7:0] at_least_one(input logic [7:0] n);
    at_least_one = (n == 8'd0) ? 8'd1 : n;
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_last,
  output logic              full,
  output logic              empty,
  output logic              frame_ready
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   fill;
  logic [CW-1:0]   frames;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full        = (fill == CW'(DEPTH));
  assign empty       = (fill == '0);
  assign frame_ready = (frames != '0);
  assign head_data   = mem[rd_ptr][DATA_W-1:0];
  assign head_last   = mem[rd_ptr][DATA_W];

  wire push_frame_end = push && push_last;
  wire pop_frame_end  = pop && head_last;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_last, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      frames <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      case ({push_frame_end, pop_frame_end})
        2'b10:   frames <= frames + 1'b1;
        2'b01:   frames <= frames - 1'b1;
        default: frames <= frames;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2

  AST_FRAMES_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= fill); // R10

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic        bit_in,
  output logic [15:0] fcs_q,
  output logic [15:0] fcs_next
);
  import hdlc_tx_pkg::*;

  assign fcs_next = crc_step(fcs_q, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fcs_q <= CRC_SEED;
    else if (clear) fcs_q <= CRC_SEED;
    else if (step)  fcs_q <= fcs_next;
  end

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_preamble,
  input  logic [CNT_W-1:0] cfg_header,
  input  logic [CNT_W-1:0] cfg_tail,
  input  logic             frame_ready,
  input  logic [7:0]       head_data,
  input  logic             head_last,
  output logic             pop,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             ptt
);
  import hdlc_tx_pkg::*;

  tx_state_t        state;
  logic [CNT_W-1:0] fcnt;
  logic [CNT_W-1:0] hdr_n, tail_n;
  logic [2:0]       bidx;
  logic [7:0]       sh;
  logic             last_r;
  logic             fcs_hi;
  logic [2:0]       ones;
  logic             stuff_pend;
  logic [15:0]      fcs_q, fcs_next;

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] n);
    floor_one = (n == '0) ? CNT_W'(1) : n;
  endfunction

  // Named internal events
  wire flag_state = (state == ST_PRE) || (state == ST_HDR) ||
                    (state == ST_SEP) || (state == ST_TAIL);
  wire stuffable  = (state == ST_DATA) || (state == ST_FCS);
  wire cur_bit    = flag_state ? FLAG_BYTE[bidx] : sh[bidx];
  wire take       = tx_valid && tx_ready;
  wire stuff_take = take && stuff_pend;
  wire real_take  = take && !stuff_pend;
  wire byte_end   = real_take && (bidx == 3'd7);
  wire last_count = (fcnt == CNT_W'(1));
  wire hdr_to_data = byte_end && (state == ST_HDR) && last_count;
  wire sep_to_data = byte_end && (state == ST_SEP);
  wire data_next   = byte_end && (state == ST_DATA) && !last_r;
  wire burst_start = (state == ST_IDLE) && frame_ready;

  assign tx_valid = (state != ST_IDLE);
  assign ptt      = tx_valid;
  assign tx_bit   = stuff_pend ? 1'b0 : cur_bit;
  assign pop      = hdr_to_data || sep_to_data || data_next;

  hdlc_tx_fcs u_fcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (hdr_to_data || sep_to_data),
    .step     (real_take && (state == ST_DATA)),
    .bit_in   (cur_bit),
    .fcs_q    (fcs_q),
    .fcs_next (fcs_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fcnt       <= '0;
      hdr_n      <= CNT_W'(1);
      tail_n     <= CNT_W'(1);
      bidx       <= '0;
      sh         <= '0;
      last_r     <= 1'b0;
      fcs_hi     <= 1'b0;
      ones       <= '0;
      stuff_pend <= 1'b0;
    end else begin
      if (stuff_take) begin
        stuff_pend <= 1'b0;
        ones       <= '0;
      end else if (real_take) begin
        bidx <= bidx + 1'b1;
        if (stuffable && cur_bit) begin
          ones       <= ones + 1'b1;
          stuff_pend <= (ones == RUN_LIMIT - 3'd1);
        end else begin
          ones <= '0;
        end
        if (bidx == 3'd7) begin
          case (state)
            ST_PRE: begin
              if (last_count) begin
                state <= ST_HDR;
                fcnt  <= hdr_n;
              end else begin
                fcnt <= fcnt - 1'b1;
              end
            end
            ST_HDR: begin
              if (last_count) begin
                state  <= ST_DATA;
                sh     <= head_data;
                last_r <= head_last;
              end else begin
                fcnt <= fcnt - 1'b1;
              end
            end
            ST_DATA: begin
              if (last_r) begin
                state  <= ST_FCS;
                fcs_hi <= 1'b0;
                sh     <= ~fcs_next[7:0];
              end else begin
                sh     <= head_data;
                last_r <= head_last;
              end
            end
            ST_FCS: begin
              if (!fcs_hi) begin
                fcs_hi <= 1'b1;
                sh     <= ~fcs_q[15:8];
              end else if (frame_ready) begin
                state <= ST_SEP;
              end else begin
                state <= ST_TAIL;
                fcnt  <= tail_n;
              end
            end
            ST_SEP: begin
              state  <= ST_DATA;
              sh     <= head_data;
              last_r <= head_last;
            end
            ST_TAIL: begin
              if (last_count) state <= ST_IDLE;
              else            fcnt  <= fcnt - 1'b1;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
      if (burst_start) begin
        hdr_n  <= floor_one(cfg_header);
        tail_n <= floor_one(cfg_tail);
        bidx   <= '0;
        ones   <= '0;
        if (cfg_preamble != '0) begin
          state <= ST_PRE;
          fcnt  <= cfg_preamble;
        end else begin
          state <= ST_HDR;
          fcnt  <= floor_one(cfg_header);
        end
      end
    end
  end

  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit))); // R8

  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> (bidx == 3'd0)); // R3

  AST_ZERO_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (real_take && stuffable && cur_bit && (ones == RUN_LIMIT - 3'd1))
      |=> (tx_valid && !tx_bit)); // R4

  AST_PTT_ENDS_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptt) |-> $past((state == ST_TAIL) && take)); // R7

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_preamble,
  input  logic [CNT_W-1:0] cfg_header,
  input  logic [CNT_W-1:0] cfg_tail,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             wr_ready,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             ptt
);

  logic       full, empty, frame_ready, pop;
  logic [7:0] head_data;
  logic       head_last;

  wire push = wr_valid && !full;
  assign wr_ready = !full;

  hdlc_tx_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .push_data   (wr_data),
    .push_last   (wr_last),
    .pop         (pop),
    .head_data   (head_data),
    .head_last   (head_last),
    .full        (full),
    .empty       (empty),
    .frame_ready (frame_ready)
  );

  hdlc_tx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_preamble (cfg_preamble),
    .cfg_header   (cfg_header),
    .cfg_tail     (cfg_tail),
    .frame_ready  (frame_ready),
    .head_data    (head_data),
    .head_last    (head_last),
    .pop          (pop),
    .tx_ready     (tx_ready),
    .tx_valid     (tx_valid),
    .tx_bit       (tx_bit),
    .ptt          (ptt)
  );

endmodule

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_preamble = 8'd0, cfg_header = 8'd0, cfg_tail = 8'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_last = 1'b0;
  logic       wr_ready;
  logic       tx_ready = 1'b0;
  logic       tx_valid, tx_bit, ptt;

  always #2.5 clk = ~clk;

  hdlc_tx_framer #(.FIFO_DEPTH(16), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_preamble(cfg_preamble), .cfg_header(cfg_header), .cfg_tail(cfg_tail),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_bit(tx_bit), .ptt(ptt)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] tx_bytes [0:63];
  int frame_len [0:3];
  int nframes;
  logic exp_bits [0:4095];
  logic cap_bits [0:4095];
  int exp_n, cap_n, open_end, body_end, e_ones;
  int hold_err, ptt_err;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic add_raw(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  task automatic add_flag();
    for (int k = 0; k < 8; k++) add_raw((k == 0 || k == 7) ? 1'b0 : 1'b1);
  endtask

  task automatic add_stuffed_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      add_raw(b[k]);
      if (b[k]) begin
        e_ones++;
        if (e_ones == 5) begin add_raw(1'b0); e_ones = 0; end
      end else e_ones = 0;
    end
  endtask

  task automatic build_expected(input int p, input int h, input int t);
    int idx;
    logic [15:0] c;
    exp_n = 0;
    idx = 0;
    for (int i = 0; i < p; i++) add_flag();
    for (int i = 0; i < ((h == 0) ? 1 : h); i++) add_flag();
    open_end = exp_n;
    for (int f = 0; f < nframes; f++) begin
      c = 16'hFFFF;
      e_ones = 0;
      for (int i = 0; i < frame_len[f]; i++) begin
        add_stuffed_byte(tx_bytes[idx]);
        c = crc_byte(c, tx_bytes[idx]);
        idx++;
      end
      c = ~c;
      add_stuffed_byte(c[7:0]);
      add_stuffed_byte(c[15:8]);
      if (f < nframes - 1) add_flag();
    end
    body_end = exp_n;
    for (int i = 0; i < ((t == 0) ? 1 : t); i++) add_flag();
  endtask

  task automatic push_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_last  = l;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic push_from(input int skip);
    int idx;
    idx = 0;
    for (int f = 0; f < nframes; f++)
      for (int i = 0; i < frame_len[f]; i++) begin
        if (idx >= skip) push_byte(tx_bytes[idx], i == frame_len[f] - 1);
        idx++;
      end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic collect();
    logic prev_stall, prev_bit;
    prev_stall = 1'b0;
    prev_bit = 1'b0;
    cap_n = 0;
    while (!ptt) @(negedge clk);
    while (ptt) begin
      if (ptt != tx_valid) ptt_err++;
      if (prev_stall && (tx_bit != prev_bit)) hold_err++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (lfsr[1:0] != 2'b00);
      if (tx_valid && tx_ready && cap_n < 4096) begin
        cap_bits[cap_n] = tx_bit;
        cap_n++;
      end
      prev_stall = tx_valid && !tx_ready;
      prev_bit = tx_bit;
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic cmp_region(input int lo, input int hi, input string tag);
    int bad, first;
    bad = 0;
    first = -1;
    for (int i = lo; i < hi; i++)
      if (i >= cap_n || cap_bits[i] !== exp_bits[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, {tag, " mismatching bits (first index in expected field)"}, bad, 0);
    if (bad != 0) $display("  first mismatch at bit %0d", first);
  endtask

  task automatic run_tx(input int p, input int h, input int t, input int skip,
                        input bit scramble, input string tag);
    cfg_preamble = 8'(p);
    cfg_header   = 8'(h);
    cfg_tail     = 8'(t);
    build_expected(p, h, t);
    fork
      push_from(skip);
      collect();
      begin
        if (scramble) begin
          while (!ptt) @(negedge clk);
          cfg_preamble = 8'd9; cfg_header = 8'd7; cfg_tail = 8'd6;
        end
      end
    join
    cmp_region(0, open_end, {tag, " R3 opening flags"});
    cmp_region(open_end, body_end, {tag, " R4 R5 R6 frame body"});
    cmp_region(body_end, exp_n, {tag, " R7 tail flags"});
    chk(cap_n == exp_n, {tag, " R7 burst length"}, cap_n, exp_n);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] c;
    hold_err = 0;
    ptt_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ptt == 1'b0, "R1 ptt after reset", int'(ptt), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);

    // R2: partial frame does not key the transmitter
    nframes = 1; frame_len[0] = 4;
    tx_bytes[0] = 8'h82; tx_bytes[1] = 8'hA0; tx_bytes[2] = 8'hA4; tx_bytes[3] = 8'h03;
    cfg_preamble = 8'd2; cfg_header = 8'd1; cfg_tail = 8'd1;
    for (int i = 0; i < 3; i++) push_byte(tx_bytes[i], 1'b0);
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(ptt == 1'b0, "R2 ptt with partial frame", int'(ptt), 0);
    chk(tx_valid == 1'b0, "R2 tx_valid with partial frame", int'(tx_valid), 0);
    run_tx(2, 1, 1, 3, 1'b0, "R2 completed frame");

    // R4: stuffing runs crossing byte boundaries and into the FCS
    nframes = 1; frame_len[0] = 4;
    tx_bytes[0] = 8'hF8; tx_bytes[1] = 8'h1F; tx_bytes[2] = 8'hFF; tx_bytes[3] = 8'hFF;
    run_tx(1, 1, 1, 0, 1'b0, "R4 stuffing");

    // R5: check value of the bench CRC, then a burst with zero counts (R11)
    c = 16'hFFFF;
    for (int i = 0; i < 9; i++) c = crc_byte(c, 8'h31 + 8'(i));
    chk((~c) == 16'h906E, "R5 reference check value", int'(~c), 16'h906E);
    nframes = 1; frame_len[0] = 9;
    for (int i = 0; i < 9; i++) tx_bytes[i] = 8'h31 + 8'(i);
    run_tx(0, 0, 0, 0, 1'b0, "R11 zero counts");
    chk(open_end == 8, "R11 single opening flag expected", open_end, 8);

    // R6 + R10: three frames in one burst, counts changed mid-burst
    nframes = 3; frame_len[0] = 3; frame_len[1] = 2; frame_len[2] = 1;
    tx_bytes[0] = 8'h7E; tx_bytes[1] = 8'h55; tx_bytes[2] = 8'h00;
    tx_bytes[3] = 8'hAA; tx_bytes[4] = 8'h7E; tx_bytes[5] = 8'h01;
    run_tx(3, 2, 3, 0, 1'b1, "R6 R10 multi-frame");

    // R10: one 16-byte frame fills the queue
    nframes = 1; frame_len[0] = 16;
    for (int i = 0; i < 16; i++) tx_bytes[i] = 8'(i * 37 + 5);
    cfg_preamble = 8'd1; cfg_header = 8'd1; cfg_tail = 8'd2;
    for (int i = 0; i < 16; i++) push_byte(tx_bytes[i], i == 15);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last = 1'b0;
    chk(wr_ready == 1'b0, "R10 wr_ready low when full", int'(wr_ready), 0);
    run_tx(1, 1, 2, 16, 1'b0, "R10 full frame");
    chk(wr_ready == 1'b1, "R10 wr_ready after drain", int'(wr_ready), 1);

    // Sweep: every single-byte frame
    nframes = 1; frame_len[0] = 1;
    for (int v = 0; v < 256; v++) begin
      tx_bytes[0] = 8'(v);
      run_tx(0, 0, 0, 0, 1'b0, "R4 sweep");
    end

    chk(hold_err == 0, "R8 offered bit held during stall", hold_err, 0);
    chk(ptt_err == 0, "R9 ptt tracks tx_valid", ptt_err, 0);
    chk(ptt == 1'b0, "R9 ptt low after bursts", int'(ptt), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule